// File: doc/BRIEF.md
# Address Aperture Decoder with External-Bus Stall Bridge

This block sits between a processor's single-word load/store port and the memory system. Every 32-bit access is sorted into one of three windows: local SDRAM, the on-chip register window, or the external bus. An SDRAM or register access is forwarded in the same cycle, with no stall. An external-bus access is turned into one single-word request to a bus-interface unit, and the processor is stalled until that unit reports completion.

The SDRAM window is bounded by a programmable lower bound and a programmable upper bound, both inclusive. The register window is 2 MB long and starts at a programmable base that is aligned to its size. Any address outside both windows is external. For an external access the block fills an address holding register and, for a store, a data holding register, then pulses a request strobe. When the bus unit raises ready, a load result is written into the same data holding register. One cycle later the stall drops and the result is returned to the processor.

The processor keeps its request and address steady until it sees a cycle with the stall low. That cycle completes the access.

Top module: `aperture_bridge`

## Requirements
- R1: After reset the register window base is 0xEFE00000, the SDRAM window is empty (lower bound 0xFFFFFFFF, upper bound 0), `cpu_stall` and `bus_req` are low, and the holding registers read 0.
- R2: An access with lower bound ≤ address ≤ upper bound (unsigned), outside the register window, raises `mem_req` in the same cycle with `cpu_stall` low.
- R3: An access whose address bits [31:21] equal those of the register base raises `reg_req` in the same cycle. The register window takes priority over an overlapping SDRAM window.
- R4: Any other access is external. `cpu_stall` is high in the cycle the request first appears, and `mem_req` and `reg_req` stay low for the whole access.
- R5: `bus_req` is a one-cycle pulse in the cycle after an external access starts. At that point `bus_addr` holds the access address and `bus_read` is 1 for a load and 0 for a store. For a store, `bus_wdata` holds the store data.
- R6: `cpu_stall` stays high until the bus unit raises `bus_ready`. It is low in the cycle after `bus_ready`, and that cycle completes the access.
- R7: For a load, the completion cycle shows `cpu_rvalid` = 1 with `cpu_rdata` equal to the `bus_rdata` value sampled with `bus_ready`. `cpu_rvalid` is low in every other cycle and for stores.
- R8: Only one external request is outstanding at a time: exactly one `bus_req` pulse per external access.
- R9: Configuration write selects 0, 1 and 2 load the lower bound, the upper bound and the register base. For the register base, bits [20:0] are forced to zero. Select 3 targets the holding registers and is ignored.
- R10: `bus_addr` and `bus_read` stay stable while a request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 lower bound, 1 upper bound, 2 register base, 3 holding (ignored) |
| cfg_wdata | input | 32 | Configuration write data |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Access address |
| cpu_wdata | input | 32 | Store data |
| cpu_stall | output | 1 | Processor hold |
| cpu_rvalid | output | 1 | External load result valid |
| cpu_rdata | output | 32 | External load result |
| mem_req | output | 1 | SDRAM access forward |
| reg_req | output | 1 | Register window access forward |
| bus_req | output | 1 | One-cycle external request strobe |
| bus_read | output | 1 | Direction to bus unit, 1 = load |
| bus_addr | output | 32 | Address holding register |
| bus_wdata | output | 32 | Data holding register |
| bus_ready | input | 1 | Bus unit completion |
| bus_rdata | input | 32 | Load data from bus unit, valid with ready |

## Verification
The bound checker watches, on every cycle, the handshake invariants. These are: the strobe is one cycle long and only appears while the processor is stalled; the stall holds until ready and drops right after it; no second strobe is issued while one is outstanding; the address holding register stays frozen; a forwarded access never coincides with a stall; and register forwarding excludes SDRAM forwarding. The scenarios that only the bench can show are tied to values: window membership at both inclusive bounds and one address beyond them, register-window priority after the base is moved into the SDRAM range, base alignment masking, the ignored holding-register select, and the returned load value under ready delays of zero, one and several cycles.

// File: rtl/ab_pkg.sv
package ab_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        AP_SDRAM = 2'd0,
        AP_REGS  = 2'd1,
        AP_EXT   = 2'd2
    } ap_kind_e;

    typedef enum logic [1:0] {
        BR_IDLE = 2'd0,
        BR_WAIT = 2'd1,
        BR_DONE = 2'd2
    } br_state_e;

    localparam logic [1:0] CFG_MEM_LO  = 2'd0;
    localparam logic [1:0] CFG_MEM_HI  = 2'd1;
    localparam logic [1:0] CFG_REG_BAS = 2'd2;

    typedef struct packed {
        logic [ADDR_W-1:0] mem_lo;
        logic [ADDR_W-1:0] mem_hi;
        logic [ADDR_W-1:0] reg_base;
    } ap_cfg_t;

    function automatic ap_kind_e classify(input logic [ADDR_W-1:0] a,
                                          input ap_cfg_t c,
                                          input int win_bits);
        if ((a >> win_bits) == (c.reg_base >> win_bits))
            return AP_REGS;
        else if (a >= c.mem_lo && a <= c.mem_hi)
            return AP_SDRAM;
        else
            return AP_EXT;
    endfunction
endpackage

// File: rtl/ab_cfg_regs.sv
module ab_cfg_regs
    import ab_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_RESET = 32'hEFE0_0000,
    parameter int WIN_BITS = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] wdata,
    output ap_cfg_t           cfg
);
    localparam logic [ADDR_W-1:0] WIN_MASK = {ADDR_W{1'b1}} << WIN_BITS;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.mem_lo   <= {ADDR_W{1'b1}};
            cfg.mem_hi   <= '0;
            cfg.reg_base <= REG_RESET & WIN_MASK;
        end else if (we) begin
            case (sel)
                CFG_MEM_LO:  cfg.mem_lo   <= wdata;
                CFG_MEM_HI:  cfg.mem_hi   <= wdata;
                CFG_REG_BAS: cfg.reg_base <= wdata & WIN_MASK;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ab_decoder.sv
module ab_decoder
    import ab_pkg::*;
#(
    parameter int WIN_BITS = 21
) (
    input  logic [ADDR_W-1:0] addr,
    input  ap_cfg_t           cfg,
    output ap_kind_e          kind
);
    always_comb kind = classify(addr, cfg, WIN_BITS);
endmodule

// File: rtl/ab_ext_ctrl.sv
module ab_ext_ctrl
    import ab_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ready,
    input  logic [DATA_W-1:0] rdata,
    output br_state_e         state,
    output logic              issue,
    output logic [ADDR_W-1:0] addr_h,
    output logic [DATA_W-1:0] data_h,
    output logic              rd_h
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= BR_IDLE;
            issue  <= 1'b0;
            addr_h <= '0;
            data_h <= '0;
            rd_h   <= 1'b0;
        end else begin
            case (state)
                BR_IDLE: begin
                    if (start) begin
                        addr_h <= addr;
                        rd_h   <= ~we;
                        if (we) data_h <= wdata;
                        issue  <= 1'b1;
                        state  <= BR_WAIT;
                    end
                end
                BR_WAIT: begin
                    issue <= 1'b0;
                    if (ready) begin
                        if (rd_h) data_h <= rdata;
                        state <= BR_DONE;
                    end
                end
                BR_DONE: state <= BR_IDLE;
                default: state <= BR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/aperture_bridge.sv
module aperture_bridge
    import ab_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_RESET = 32'hEFE0_0000,
    parameter int WIN_BITS = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_stall,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              reg_req,
    output logic              bus_req,
    output logic              bus_read,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata
);
    ap_cfg_t   cfg;
    ap_kind_e  kind;
    br_state_e state;
    logic      idle;
    logic      start;
    logic      rd_h;
    logic [DATA_W-1:0] data_h;

    ab_cfg_regs #(.REG_RESET(REG_RESET), .WIN_BITS(WIN_BITS)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .cfg(cfg)
    );

    ab_decoder #(.WIN_BITS(WIN_BITS)) u_dec (
        .addr(cpu_addr), .cfg(cfg), .kind(kind)
    );

    assign idle  = (state == BR_IDLE);
    assign start = idle && cpu_req && (kind == AP_EXT);

    ab_ext_ctrl u_ext (
        .clk(clk), .rst(rst), .start(start), .we(cpu_we),
        .addr(cpu_addr), .wdata(cpu_wdata), .ready(bus_ready),
        .rdata(bus_rdata), .state(state), .issue(bus_req),
        .addr_h(bus_addr), .data_h(data_h), .rd_h(rd_h)
    );

    assign mem_req    = idle && cpu_req && (kind == AP_SDRAM);
    assign reg_req    = idle && cpu_req && (kind == AP_REGS);
    assign cpu_stall  = start || (state == BR_WAIT);
    assign cpu_rvalid = (state == BR_DONE) && rd_h;
    assign cpu_rdata  = data_h;
    assign bus_wdata  = data_h;
    assign bus_read   = rd_h;
endmodule

// File: rtl/ab_checker.sv
module ab_checker (
    input logic        clk,
    input logic        rst,
    input logic        cpu_stall,
    input logic        cpu_rvalid,
    input logic        mem_req,
    input logic        reg_req,
    input logic        bus_req,
    input logic        bus_read,
    input logic        bus_ready,
    input logic [31:0] bus_addr
);
    logic wait_q;
    logic outstanding;

    assign outstanding = bus_req || wait_q;

    always_ff @(posedge clk) begin
        if (rst) wait_q <= 1'b0;
        else     wait_q <= outstanding && !bus_ready;
    end

    p_strobe_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> !bus_req);

    p_strobe_under_stall_r6: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> cpu_stall);

    p_stall_held_r6: assert property (@(posedge clk) disable iff (rst)
        (outstanding && !bus_ready) |=> cpu_stall);

    p_ready_releases_r6: assert property (@(posedge clk) disable iff (rst)
        (outstanding && bus_ready) |=> !cpu_stall);

    p_single_outstanding_r8: assert property (@(posedge clk) disable iff (rst)
        wait_q |-> !bus_req);

    p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
        wait_q |-> ($stable(bus_addr) && $stable(bus_read)));

    p_no_forward_in_stall_r4: assert property (@(posedge clk) disable iff (rst)
        cpu_stall |-> (!mem_req && !reg_req));

    p_reg_excludes_mem_r3: assert property (@(posedge clk) disable iff (rst)
        reg_req |-> !mem_req);

    p_rvalid_after_ready_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_rvalid |-> (!cpu_stall && $past(bus_ready)));
endmodule

bind aperture_bridge ab_checker u_chk (
    .clk(clk), .rst(rst), .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid),
    .mem_req(mem_req), .reg_req(reg_req), .bus_req(bus_req),
    .bus_read(bus_read), .bus_ready(bus_ready), .bus_addr(bus_addr)
);

// File: tb/sim_aperture_bridge.sv
module sim_aperture_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_stall, cpu_rvalid, mem_req, reg_req, bus_req, bus_read;
    logic [31:0] cpu_rdata, bus_addr, bus_wdata;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #2 clk = ~clk;

    aperture_bridge u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .reg_req(reg_req), .bus_req(bus_req), .bus_read(bus_read),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_lo, m_hi, m_reg, m_addr, m_data;
    logic        m_rd, m_first;
    int          m_st;

    function automatic int mclass(input logic [31:0] a);
        if (a[31:21] == m_reg[31:21]) return 1;
        if (a >= m_lo && a <= m_hi) return 0;
        return 2;
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", r, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_lo = 32'hFFFF_FFFF; m_hi = 0; m_reg = 32'hEFE0_0000;
            m_addr = 0; m_data = 0; m_rd = 0; m_first = 0; m_st = 0;
        end else begin
            if (cfg_we) begin
                if (cfg_sel == 2'd0) m_lo = cfg_wdata;
                else if (cfg_sel == 2'd1) m_hi = cfg_wdata;
                else if (cfg_sel == 2'd2) m_reg = {cfg_wdata[31:21], 21'd0};
            end
            if (m_st == 0) begin
                if (cpu_req && mclass(cpu_addr) == 2) begin
                    m_addr = cpu_addr; m_rd = !cpu_we;
                    if (cpu_we) m_data = cpu_wdata;
                    m_first = 1; m_st = 1;
                end
            end else if (m_st == 1) begin
                m_first = 0;
                if (bus_ready) begin
                    if (m_rd) m_data = bus_rdata;
                    m_st = 2;
                end
            end else m_st = 0;
        end
        if (cyc > 20000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected finished", cyc);
            finish_run();
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic e_mem, e_reg, e_stall, e_breq, e_rv;
            int k;
            k = mclass(cpu_addr);
            e_mem = (m_st == 0) && cpu_req && k == 0;
            e_reg = (m_st == 0) && cpu_req && k == 1;
            e_stall = ((m_st == 0) && cpu_req && k == 2) || m_st == 1;
            e_breq = (m_st == 1) && m_first;
            e_rv = (m_st == 2) && m_rd;
            chk("R2 mem_req", {31'd0, mem_req}, {31'd0, e_mem});
            chk("R3 reg_req", {31'd0, reg_req}, {31'd0, e_reg});
            chk("R6 cpu_stall", {31'd0, cpu_stall}, {31'd0, e_stall});
            chk("R5 bus_req", {31'd0, bus_req}, {31'd0, e_breq});
            chk("R5 bus_read", {31'd0, bus_read}, {31'd0, m_rd});
            chk("R5 bus_addr", bus_addr, m_addr);
            chk("R5 bus_wdata", bus_wdata, m_data);
            chk("R7 cpu_rvalid", {31'd0, cpu_rvalid}, {31'd0, e_rv});
            chk("R7 cpu_rdata", cpu_rdata, m_data);
        end
    end

    task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
        cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic local_access(input logic [31:0] a, input logic we,
                                input logic exp_mem, input logic exp_reg,
                                input string tag);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = a ^ 32'h5A5A_5A5A;
        @(negedge clk);
        chk(tag, {29'd0, mem_req, reg_req, cpu_stall}, {29'd0, exp_mem, exp_reg, 1'b0});
        @(posedge clk); #1;
        cpu_req = 0;
    endtask

    task automatic ext_access(input logic [31:0] a, input logic we,
                              input logic [31:0] d, input int delay);
        int pulses;
        logic [31:0] a0;
        pulses = 0;
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        chk("R4 stall on first cycle", {31'd0, cpu_stall}, 32'd1);
        @(posedge clk); #1;
        @(negedge clk);
        if (bus_req) pulses++;
        a0 = bus_addr;
        for (int i = 0; i < delay; i++) begin
            @(posedge clk); #1;
            @(negedge clk);
            if (bus_req) pulses++;
            chk("R10 address held while waiting", bus_addr, a0);
            chk("R6 stall held before ready", {31'd0, cpu_stall}, 32'd1);
        end
        bus_ready = 1; bus_rdata = d;
        @(posedge clk); #1;
        bus_ready = 0; bus_rdata = 32'hDEAD_BEEF;
        @(negedge clk);
        chk("R8 one strobe per access", pulses, 1);
        chk("R6 stall released after ready", {31'd0, cpu_stall}, 32'd0);
        if (!we) chk("R7 load data returned", cpu_rdata, d);
        chk("R7 rvalid only for loads", {31'd0, cpu_rvalid}, {31'd0, !we});
        @(posedge clk); #1;
        cpu_req = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R1 stall after reset", {31'd0, cpu_stall}, 32'd0);
        chk("R1 bus_req after reset", {31'd0, bus_req}, 32'd0);
        chk("R1 holding address", bus_addr, 32'd0);
        @(posedge clk); #1;
        local_access(32'hEFE0_0004, 0, 0, 1, "R1 default register base");
        ext_access(32'h1000_0000, 0, 32'h1111_2222, 0);   // R1 SDRAM empty
        cfg_write(2'd0, 32'h1000_0000);
        cfg_write(2'd1, 32'h10FF_FFFF);
        local_access(32'h1000_0000, 0, 1, 0, "R2 lower bound inclusive");
        local_access(32'h10FF_FFFF, 1, 1, 0, "R2 upper bound inclusive");
        local_access(32'h1080_0000, 0, 1, 0, "R2 middle of window");
        ext_access(32'h1100_0000, 0, 32'hCAFE_0001, 1);  // R4 just above upper bound
        ext_access(32'h0FFF_FFFC, 1, 32'h0BAD_F00D, 3);  // R4 just below lower bound, store
        local_access(32'hEFFF_FFFC, 0, 0, 1, "R3 top of register window");
        ext_access(32'hF000_0000, 0, 32'h8765_4321, 5);  // R4 just past register window
        cfg_write(2'd2, 32'h1023_4567);                   // R9 masked to 0x10200000
        local_access(32'h1020_0000, 0, 0, 1, "R3 register window wins overlap");
        local_access(32'h103F_FFFF, 0, 0, 1, "R9 base low bits masked");
        local_access(32'h1040_0000, 0, 1, 0, "R9 SDRAM above moved window");
        ext_access(32'h2000_0000, 1, 32'h4444_5555, 2);
        cfg_write(2'd3, 32'h9999_9999);
        @(negedge clk);
        chk("R9 holding data ignores select 3", bus_wdata, 32'h4444_5555);
        chk("R9 holding address ignores select 3", bus_addr, 32'h2000_0000);
        @(posedge clk); #1;
        ext_access(32'h7000_0010, 0, 32'h0000_ABCD, 0);
        ext_access(32'h7000_0020, 1, 32'hFFFF_0000, 0);
        repeat (3) @(posedge clk);
        #1 finish_run();
    end
endmodule